// File: doc/BRIEF.md
# Isochronous IN Interval Flush Controller

This block supervises the timing of a single isochronous IN pipe in a USB function controller. It keeps its own notion of (micro)frame boundaries from two sources. One is a pulse for each correctly received start-of-frame packet. The other is a local cycle timer that produces a substitute boundary when no good start-of-frame arrives on time. From those boundaries and a programmable interval it decides which frame in each polling window is the one where the host should send an IN token.

When flushing is enabled and the expected token fails to appear in that frame, the block pulses a FIFO clear at the next boundary while the FIFO holds data. A token received with a bus error counts as missing. The transmit FIFO then drops data the host will never collect. When flushing is disabled, every IN token is answered and the FIFO is never cleared.

Every input and output is a plain level or pulse sampled on `clk`. No data stream passes through the block, so there is no valid/ready pair and no back-pressure. Event inputs are one-cycle pulses, and the clear output is a one-cycle pulse.

Top module: `iso_in_flush_ctrl`

## Requirements
- R1: With `flush_en` low, `tx_permit` is 1 in every cycle and `fifo_clear` never pulses, whatever the interval setting and token activity.
- R2: With `flush_en` high and interval 0, every frame expects a token. If a frame ends with no good token while `fifo_has_data` is high, `fifo_clear` is 1 in the cycle right after the boundary edge.
- R3: No clear is issued at a boundary when `fifo_has_data` is low in the boundary cycle.
- R4: A good token (`in_tok_ok`) in the expected frame cancels that frame's clear. This still holds when it follows an errored token in the same frame.
- R5: An errored token (`in_tok_err`) counts as not received. It makes the current frame owe a clear at its ending boundary, including a frame that did not expect a token.
- R6: If no `sof_valid` arrives for HS_CYC+TOL cycles (`high_speed`=1) or FS_CYC+TOL cycles (`high_speed`=0) after the previous boundary, a substitute boundary occurs on that cycle and acts exactly like a received SOF.
- R7: The interval field `ivl_in` (3 bits, loaded on `ivl_wr`) sets a window of 2^value frames. Only the first frame of each window expects a token, and with `flush_en` high `tx_permit` is 1 only during that frame.
- R8: After a restart with a nonzero interval, the window starts at the next frame boundary, and that new frame is the expected one. Until then `tx_permit` is 0 (with `flush_en` high) and no frame owes a clear.
- R9: `autoclr_wr` and `bus_reset` each restart the window. Hardware reset (`rst_n` low) also restarts it and forces the interval to 0, so after reset the frame in progress is already expected.
- R10: `fifo_clear` is a pulse lasting exactly one cycle per owing boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, also clears the interval |
| high_speed | input | 1 | 1 selects the micro-frame period, 0 the full-speed frame period |
| sof_valid | input | 1 | Pulse: start-of-frame received without error |
| in_tok_ok | input | 1 | Pulse: IN token for this pipe received correctly |
| in_tok_err | input | 1 | Pulse: IN token received with a bus error |
| fifo_has_data | input | 1 | Transmit FIFO holds data to send |
| flush_en | input | 1 | Enables interval supervision and flushing |
| ivl_wr | input | 1 | Pulse: load `ivl_in` as the interval exponent |
| ivl_in | input | 3 | Interval exponent (window = 2^value frames) |
| autoclr_wr | input | 1 | Pulse: software restart of the interval window |
| bus_reset | input | 1 | Pulse: USB bus reset detected, restarts the window |
| fifo_clear | output | 1 | One-cycle request to clear the transmit FIFO |
| tx_permit | output | 1 | A data packet may be sent in answer to an IN token now |

## Verification
The bench builds the block with HS_CYC=16, FS_CYC=32 and TOL=2, so the substitute boundary arrives after 18 or 34 cycles of silence. Both timer modes and chained substitute ticks can then be reached in a few hundred cycles, while normal frames of about ten cycles never reach the timeout. Interval exponents 0 and 2 cover the every-frame case and a four-frame window with expected and non-expected slots, and the restart sources are placed in the middle of a window.

// File: rtl/iso_flush_pkg.sv
package iso_flush_pkg;
  localparam int IVL_W = 3;
  localparam int CNT_W = (1 << IVL_W) - 1;

  typedef logic [IVL_W-1:0] ivl_t;
  typedef logic [CNT_W-1:0] fcnt_t;

  // Mask for a window of 2^ivl frames.
  function automatic fcnt_t win_mask(ivl_t ivl);
    logic [CNT_W:0] top;
    top = (CNT_W+1)'(1) << ivl;
    return top[CNT_W-1:0] - 1'b1;
  endfunction
endpackage

// File: rtl/iso_frame_timer.sv
module iso_frame_timer #(
  parameter int HS_CYC = 7500,
  parameter int FS_CYC = 60000,
  parameter int TOL    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic high_speed,
  input  logic sof_valid,
  output logic frame_tick,
  output logic synth_tick
);
  localparam int LIM_HS = HS_CYC + TOL;
  localparam int LIM_FS = FS_CYC + TOL;
  localparam int LIM_MX = (LIM_FS > LIM_HS) ? LIM_FS : LIM_HS;
  localparam int CW     = $clog2(LIM_MX + 1);

  logic [CW-1:0] tim_q;
  logic [CW-1:0] lim;

  assign lim        = high_speed ? CW'(LIM_HS - 1) : CW'(LIM_FS - 1);
  assign synth_tick = !sof_valid && (tim_q >= lim);
  assign frame_tick = sof_valid || synth_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tim_q <= '0;
    else if (frame_tick) tim_q <= '0;
    else                 tim_q <= tim_q + 1'b1;
  end
endmodule

// File: rtl/iso_interval_seq.sv
module iso_interval_seq
  import iso_flush_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ivl_wr,
  input  ivl_t ivl_in,
  input  logic restart,
  input  logic frame_tick,
  output logic expected_now,
  output logic expected_next,
  output logic ivl_zero
);
  ivl_t  ivl_q;
  fcnt_t cnt_q;
  fcnt_t cnt_inc;
  logic  started_q;

  assign cnt_inc       = (cnt_q + 1'b1) & win_mask(ivl_q);
  assign ivl_zero      = (ivl_q == '0);
  assign expected_now  = started_q && (cnt_q == '0);
  assign expected_next = !started_q || (cnt_inc == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q     <= '0;
      cnt_q     <= '0;
      started_q <= 1'b1;
    end else begin
      if (ivl_wr) ivl_q <= ivl_in;
      if (restart) begin
        cnt_q     <= '0;
        started_q <= ivl_zero;
      end else if (frame_tick) begin
        if (!started_q) begin
          started_q <= 1'b1;
          cnt_q     <= '0;
        end else begin
          cnt_q <= cnt_inc;
        end
      end
    end
  end
endmodule

// File: rtl/iso_flush_judge.sv
module iso_flush_judge (
  input  logic clk,
  input  logic rst_n,
  input  logic flush_en,
  input  logic fifo_has_data,
  input  logic tok_ok,
  input  logic tok_err,
  input  logic frame_tick,
  input  logic restart,
  input  logic expected_now,
  input  logic expected_next,
  input  logic ivl_zero,
  output logic fifo_clear,
  output logic tx_permit
);
  logic owed_q;
  logic owed_end;

  // A good token wins over an error in the same cycle.
  assign owed_end  = tok_ok ? 1'b0 : (tok_err ? 1'b1 : owed_q);
  assign tx_permit = !flush_en || expected_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q     <= 1'b1;
      fifo_clear <= 1'b0;
    end else begin
      fifo_clear <= frame_tick && !restart && flush_en && fifo_has_data && owed_end;
      if (restart)         owed_q <= ivl_zero;
      else if (frame_tick) owed_q <= expected_next;
      else                 owed_q <= owed_end;
    end
  end
endmodule

// File: rtl/iso_in_flush_ctrl.sv
module iso_in_flush_ctrl #(
  parameter int HS_CYC = 7500,
  parameter int FS_CYC = 60000,
  parameter int TOL    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       high_speed,
  input  logic       sof_valid,
  input  logic       in_tok_ok,
  input  logic       in_tok_err,
  input  logic       fifo_has_data,
  input  logic       flush_en,
  input  logic       ivl_wr,
  input  logic [2:0] ivl_in,
  input  logic       autoclr_wr,
  input  logic       bus_reset,
  output logic       fifo_clear,
  output logic       tx_permit
);
  logic frame_tick, synth_tick, restart;
  logic expected_now, expected_next, ivl_zero;

  assign restart = autoclr_wr || bus_reset;

  iso_frame_timer #(.HS_CYC(HS_CYC), .FS_CYC(FS_CYC), .TOL(TOL)) timer_i (
    .clk(clk), .rst_n(rst_n), .high_speed(high_speed), .sof_valid(sof_valid),
    .frame_tick(frame_tick), .synth_tick(synth_tick)
  );

  iso_interval_seq seq_i (
    .clk(clk), .rst_n(rst_n), .ivl_wr(ivl_wr), .ivl_in(ivl_in),
    .restart(restart), .frame_tick(frame_tick),
    .expected_now(expected_now), .expected_next(expected_next), .ivl_zero(ivl_zero)
  );

  iso_flush_judge judge_i (
    .clk(clk), .rst_n(rst_n), .flush_en(flush_en), .fifo_has_data(fifo_has_data),
    .tok_ok(in_tok_ok), .tok_err(in_tok_err), .frame_tick(frame_tick),
    .restart(restart), .expected_now(expected_now), .expected_next(expected_next),
    .ivl_zero(ivl_zero), .fifo_clear(fifo_clear), .tx_permit(tx_permit)
  );
endmodule

// File: rtl/iso_in_flush_chk.sv
module iso_in_flush_chk (
  input logic clk,
  input logic rst_n,
  input logic sof_valid,
  input logic in_tok_ok,
  input logic fifo_has_data,
  input logic flush_en,
  input logic fifo_clear,
  input logic tx_permit,
  input logic frame_tick,
  input logic synth_tick,
  input logic restart,
  input logic ivl_zero,
  input logic expected_now
);
  p_off_no_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clear |-> $past(flush_en));
  p_off_permit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_en |-> tx_permit);
  p_clear_at_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clear |-> $past(frame_tick));
  p_clear_needs_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clear |-> $past(fifo_has_data));
  p_good_token_cancels_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clear |-> !$past(in_tok_ok));
  p_synth_only_without_sof_r6: assert property (@(posedge clk) disable iff (!rst_n)
    synth_tick |-> !sof_valid);
  p_restart_defers_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !ivl_zero) |=> !expected_now);
endmodule

bind iso_in_flush_ctrl iso_in_flush_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sof_valid(sof_valid), .in_tok_ok(in_tok_ok),
  .fifo_has_data(fifo_has_data), .flush_en(flush_en), .fifo_clear(fifo_clear),
  .tx_permit(tx_permit), .frame_tick(frame_tick), .synth_tick(synth_tick),
  .restart(restart), .ivl_zero(ivl_zero), .expected_now(expected_now)
);

// File: tb/iso_in_flush_ctrl_tb_top.sv
module iso_in_flush_ctrl_tb_top;
  localparam int CLK_NS = 10;
  localparam int HS = 16, FS = 32, TOL = 2;
  localparam int LIM_HS = HS + TOL, LIM_FS = FS + TOL;

  logic clk = 0, rst_n = 0, high_speed = 1, sof_valid = 0;
  logic in_tok_ok = 0, in_tok_err = 0, fifo_has_data = 0, flush_en = 0;
  logic ivl_wr = 0, autoclr_wr = 0, bus_reset = 0;
  logic [2:0] ivl_in = 0;
  logic fifo_clear, tx_permit;

  iso_in_flush_ctrl #(.HS_CYC(HS), .FS_CYC(FS), .TOL(TOL)) dut_i (.*);

  always #(CLK_NS/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  string cur_req = "R1";
  int exp_q[$];

  // Bench model of the frame window
  int m_ivl = 0, m_cnt = 0, last_sof = 0;
  bit m_started = 1, m_owed = 1;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  // Monitor: pops expected clear cycles and compares
  always @(negedge clk) if (rst_n && !done) begin
    while (exp_q.size() > 0 && exp_q[0] < cyc) begin
      chk(0, "R2", "clear missing at cycle", 0, exp_q[0]);
      void'(exp_q.pop_front());
    end
    if (fifo_clear) begin
      if (exp_q.size() > 0 && exp_q[0] == cyc) begin
        void'(exp_q.pop_front());
        chk(1, "R10", "clear pulse", 1, 1);
      end else chk(0, cur_req, "unexpected or stretched clear at cycle", cyc, -1);
    end
  end

  task automatic model_boundary(int at);
    if (flush_en && fifo_has_data && m_owed) exp_q.push_back(at);
    if (!m_started) begin m_started = 1; m_cnt = 0; end
    else m_cnt = (m_cnt + 1) % (1 << m_ivl);
    m_owed = (m_cnt == 0);
  endtask

  function automatic bit exp_permit();
    return !flush_en || (m_started && m_cnt == 0);
  endfunction

  task automatic chk_permit(string req);
    chk(tx_permit == exp_permit(), req, "tx_permit", tx_permit, exp_permit());
  endtask

  task automatic sof(string req);
    @(negedge clk);
    model_boundary(cyc + 1);
    last_sof = cyc + 1;
    sof_valid = 1;
    @(negedge clk);
    sof_valid = 0;
    chk_permit(req);
  endtask

  task automatic tok(bit err);
    @(negedge clk);
    if (err) begin in_tok_err = 1; m_owed = 1; end
    else     begin in_tok_ok  = 1; m_owed = 0; end
    @(negedge clk);
    in_tok_ok = 0; in_tok_err = 0;
  endtask

  // kind: 0 none, 1 good, 2 error, 3 error then good
  task automatic frame(int kind, string req);
    sof(req);
    if (kind == 1) tok(0);
    if (kind >= 2) tok(1);
    if (kind == 3) tok(0);
    repeat (3) @(negedge clk);
  endtask

  task automatic restart(bit bus, string req);
    @(negedge clk);
    if (bus) bus_reset = 1; else autoclr_wr = 1;
    m_started = (m_ivl == 0); m_cnt = 0; m_owed = m_started;
    @(negedge clk);
    bus_reset = 0; autoclr_wr = 0;
    chk_permit(req);
  endtask

  task automatic set_ivl(int v);
    @(negedge clk);
    ivl_wr = 1; ivl_in = 3'(v); m_ivl = v;
    @(negedge clk);
    ivl_wr = 0;
  endtask

  task automatic synth_wait(int lim, string req);
    int at;
    at = last_sof + lim;
    model_boundary(at);
    last_sof = at;
    while (cyc < at) @(negedge clk);
    chk_permit(req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(0, "R2", "watchdog expired", 0, 1);
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(fifo_clear == 0, "R9", "reset fifo_clear", fifo_clear, 0);
    chk_permit("R9");
    rst_n = 1;

    // R1: supervision off
    cur_req = "R1";
    fifo_has_data = 1;
    set_ivl(2);
    for (int i = 0; i < 4; i++) frame(0, "R1");
    frame(2, "R1");
    set_ivl(0);
    restart(0, "R1");

    // R2, R3, R4: every frame expected
    flush_en = 1;
    cur_req = "R2";
    frame(0, "R2");
    frame(0, "R2");
    frame(1, "R4");
    cur_req = "R4";
    frame(1, "R4");
    cur_req = "R3";
    fifo_has_data = 0;
    frame(0, "R3");
    frame(0, "R3");
    fifo_has_data = 1;
    // R5: error tokens
    cur_req = "R5";
    frame(2, "R5");
    frame(3, "R4");
    frame(1, "R5");

    // R7, R8: four-frame window
    cur_req = "R8";
    set_ivl(2);
    restart(0, "R8");
    chk(tx_permit == 0, "R8", "permit before window start", tx_permit, 0);
    @(negedge clk);
    frame(0, "R8");
    cur_req = "R7";
    for (int i = 0; i < 8; i++) frame(0, "R7");
    frame(2, "R5");
    frame(0, "R7");
    frame(1, "R7");
    frame(0, "R7");

    // R9: bus reset mid window, then hardware reset
    cur_req = "R9";
    frame(0, "R9");
    restart(1, "R9");
    frame(0, "R9");
    frame(0, "R9");
    @(negedge clk);
    rst_n = 0;
    m_ivl = 0; m_started = 1; m_cnt = 0; m_owed = 1;
    @(negedge clk);
    chk(fifo_clear == 0, "R9", "fifo_clear in reset", fifo_clear, 0);
    rst_n = 1;
    chk_permit("R9");
    @(negedge clk);
    last_sof = cyc;
    frame(0, "R9");

    // R6: substitute boundaries, high then full speed
    cur_req = "R6";
    frame(1, "R6");
    synth_wait(LIM_HS, "R6");
    synth_wait(LIM_HS, "R6");
    sof("R6");
    @(negedge clk);
    high_speed = 0;
    synth_wait(LIM_FS, "R6");
    tok(0);
    synth_wait(LIM_FS, "R6");
    sof("R6");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "pending expected clears", exp_q.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule